// File: doc/BRIEF.md
# External Memory and I/O Bus Strobe Sequencer

This block turns one internal transfer request into a registered sequence of strobes for an 8-bit processor's external bus. One request carries the address, the space (memory or I/O), the direction, the write byte and a 3-bit wait count. The block then drives the address, one of two chip selects, and the matching read or write strobe. It also drives a data buffer enable and a drive enable for the shared data bus. A transfer runs through an address clock, any wait clocks and a final clock. At the closing edge of the final clock a read byte is captured, and a one-cycle completion pulse follows.

An instruction fetch can be flagged as speculative. If a new request arrives during the address clock of such a fetch, the fetch is dropped. The address and select move to the new target, and the strobe timing starts again from there, so an aborted fetch never shows a strobe. Every output is a flop output, so no strobe can glitch. A request is taken only while the sequencer is idle or is in the address clock of a speculative fetch.

Top module: `xbus_seq`

## Requirements
- R1: After reset all strobes, both chip selects and the buffer enable are high (inactive), the data drive enable is low and the completion pulse is low.
- R2: In the first clock after a request is taken, the address and the chip select are driven and no read or write strobe and no buffer enable is low.
- R3: A read or write strobe goes low only one clock after the address and chip select became final. Address and chip select stay unchanged for as long as the strobe is low.
- R4: A memory transfer (req_io=0) uses mem_cs_n with oe_n for a read or we_n for a write. An I/O transfer (req_io=1) uses io_cs_n with iord_n for a read or iowr_n for a write. No other select or strobe goes low.
- R5: An I/O transfer presents only the low 16 address bits, and address bits 19..16 are zero.
- R6: A memory read (req_io=0, req_wr=0) holds its strobe low for req_waits+1 clocks, so a wait count of zero gives a single strobe clock.
- R7: A memory write, an I/O read and an I/O write each hold their strobe low for req_waits+2 clocks, so at least one wait clock is always inserted.
- R8: For writes, bus_dout_en is high and bus_dout equals the request's write byte during exactly the strobe clocks. For reads, bus_dout_en stays low.
- R9: buf_en_n is low in exactly the clocks where a read or write strobe is low.
- R10: done is high for one clock, directly after the last strobe clock. In that clock all strobes and selects are high, and for reads rd_data holds the bus_din value present in the last strobe clock.
- R11: A request taken while a speculative memory-read fetch (req_spec=1) is in its address clock replaces that fetch. The bus moves to the new address with no strobe, and the new transfer then runs its full timing.
- R12: req_valid is ignored while a transfer is past its address clock or is not speculative. The address and strobe count of the running transfer are unchanged, and no second transfer follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one clock |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_spec | input | 1 | Marks an abortable speculative fetch (memory read only) |
| req_addr | input | 20 | Transfer address |
| req_wdata | input | 8 | Write byte |
| req_waits | input | 3 | Extra wait clocks added on top of the minimum |
| bus_din | input | 8 | Data bus input |
| bus_addr | output | 20 | External address |
| mem_cs_n | output | 1 | Memory chip select, active low |
| io_cs_n | output | 1 | I/O chip select, active low |
| oe_n | output | 1 | Memory output enable, active low |
| we_n | output | 1 | Memory write enable, active low |
| iord_n | output | 1 | I/O read strobe, active low |
| iowr_n | output | 1 | I/O write strobe, active low |
| buf_en_n | output | 1 | Data buffer enable, active low |
| bus_dout | output | 8 | Data bus output byte |
| bus_dout_en | output | 1 | Data bus drive enable |
| rd_data | output | 8 | Captured read byte |
| done | output | 1 | Completion pulse |

## Verification
The bench uses the default parameters: a 20-bit address, a 16-bit I/O address, an 8-bit data path, a 3-bit wait count, no minimum wait for memory reads and a one-clock minimum for the other transfer kinds. With these values it can exercise the zero-wait memory read, the forced wait on the other three transfer kinds and the largest wait count of seven. I/O address truncation is checked against an address whose upper nibble is not zero. The speculative abort is checked by retargeting from a fetch into both a memory write and an I/O read.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ADDR = 2'd1,
      PH_WAIT = 2'd2,
      PH_LAST = 2'd3
   } phase_e;

   typedef struct packed {
      logic io;
      logic wr;
      logic spec;
   } kind_t;
endpackage

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
   import xbus_pkg::*;
#(
   parameter int ADDR_W     = 20,
   parameter int DATA_W     = 8,
   parameter int WAIT_W     = 3,
   parameter int MEM_RD_MIN = 0,
   parameter int OTHER_MIN  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_io,
   input  logic              req_wr,
   input  logic              req_spec,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [WAIT_W-1:0] req_waits,
   input  logic [DATA_W-1:0] bus_din,
   output phase_e            nxt_phase,
   output kind_t             nxt_kind,
   output logic [ADDR_W-1:0] nxt_addr,
   output logic [DATA_W-1:0] nxt_wdata,
   output logic              done,
   output logic [DATA_W-1:0] rd_data
);
   localparam int CNT_W = WAIT_W + 1;

   phase_e            cur_phase;
   kind_t             cur_kind;
   logic [ADDR_W-1:0] cur_addr;
   logic [DATA_W-1:0] cur_wdata;
   logic [CNT_W-1:0]  cnt, nxt_cnt;
   logic              take;
   logic [CNT_W-1:0]  eff_waits;
   logic              is_mem_rd;

   assign is_mem_rd = ~req_io & ~req_wr;
   assign eff_waits = CNT_W'(req_waits)
                    + (is_mem_rd ? CNT_W'(MEM_RD_MIN) : CNT_W'(OTHER_MIN));
   assign take = req_valid &&
                 ((cur_phase == PH_IDLE) || (cur_phase == PH_ADDR && cur_kind.spec));

   always_comb begin
      nxt_phase = cur_phase;
      nxt_kind  = cur_kind;
      nxt_addr  = cur_addr;
      nxt_wdata = cur_wdata;
      nxt_cnt   = cnt;
      if (take) begin
         nxt_phase     = PH_ADDR;
         nxt_kind.io   = req_io;
         nxt_kind.wr   = req_wr;
         nxt_kind.spec = req_spec & is_mem_rd;
         nxt_addr      = req_addr;
         nxt_wdata     = req_wdata;
         nxt_cnt       = eff_waits;
      end else begin
         case (cur_phase)
            PH_ADDR: begin
               nxt_kind.spec = 1'b0;
               nxt_phase     = (cnt != '0) ? PH_WAIT : PH_LAST;
            end
            PH_WAIT: begin
               nxt_cnt = cnt - CNT_W'(1);
               if (cnt == CNT_W'(1)) nxt_phase = PH_LAST;
            end
            PH_LAST: nxt_phase = PH_IDLE;
            default: nxt_phase = PH_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_phase <= PH_IDLE;
         cur_kind  <= '0;
         cur_addr  <= '0;
         cur_wdata <= '0;
         cnt       <= '0;
         done      <= 1'b0;
         rd_data   <= '0;
      end else begin
         cur_phase <= nxt_phase;
         cur_kind  <= nxt_kind;
         cur_addr  <= nxt_addr;
         cur_wdata <= nxt_wdata;
         cnt       <= nxt_cnt;
         done      <= (cur_phase == PH_LAST);
         if (cur_phase == PH_LAST && !cur_kind.wr) rd_data <= bus_din;
      end
   end

   // R12: a running non-speculative transfer keeps its target
   a_r12_hold_target: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_phase == PH_WAIT) |=> $stable(cur_addr) && $stable(cur_kind.wr));
   // R10: a completion pulse never lasts two clocks
   a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

// File: rtl/xbus_drive.sv
module xbus_drive
   import xbus_pkg::*;
#(
   parameter int ADDR_W    = 20,
   parameter int IO_ADDR_W = 16,
   parameter int DATA_W    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  phase_e            nxt_phase,
   input  kind_t             nxt_kind,
   input  logic [ADDR_W-1:0] nxt_addr,
   input  logic [DATA_W-1:0] nxt_wdata,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              mem_cs_n,
   output logic              io_cs_n,
   output logic              oe_n,
   output logic              we_n,
   output logic              iord_n,
   output logic              iowr_n,
   output logic              buf_en_n,
   output logic [DATA_W-1:0] bus_dout,
   output logic              bus_dout_en
);
   logic [ADDR_W-1:0] io_view;
   logic [ADDR_W-1:0] sel_addr;
   logic              act, strb;

   generate
      if (IO_ADDR_W < ADDR_W) begin : g_io_pad
         assign io_view = {{(ADDR_W-IO_ADDR_W){1'b0}}, nxt_addr[IO_ADDR_W-1:0]};
      end else begin : g_io_full
         assign io_view = nxt_addr;
      end
   endgenerate

   assign sel_addr = nxt_kind.io ? io_view : nxt_addr;
   assign act      = (nxt_phase != PH_IDLE);
   assign strb     = (nxt_phase == PH_WAIT) || (nxt_phase == PH_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_addr    <= '0;
         mem_cs_n    <= 1'b1;
         io_cs_n     <= 1'b1;
         oe_n        <= 1'b1;
         we_n        <= 1'b1;
         iord_n      <= 1'b1;
         iowr_n      <= 1'b1;
         buf_en_n    <= 1'b1;
         bus_dout    <= '0;
         bus_dout_en <= 1'b0;
      end else begin
         if (act) bus_addr <= sel_addr;
         if (act && nxt_kind.wr) bus_dout <= nxt_wdata;
         mem_cs_n    <= ~(act & ~nxt_kind.io);
         io_cs_n     <= ~(act &  nxt_kind.io);
         oe_n        <= ~(strb & ~nxt_kind.io & ~nxt_kind.wr);
         we_n        <= ~(strb & ~nxt_kind.io &  nxt_kind.wr);
         iord_n      <= ~(strb &  nxt_kind.io & ~nxt_kind.wr);
         iowr_n      <= ~(strb &  nxt_kind.io &  nxt_kind.wr);
         buf_en_n    <= ~strb;
         bus_dout_en <= strb & nxt_kind.wr;
      end
   end

   logic any_strb_n;
   assign any_strb_n = oe_n & we_n & iord_n & iowr_n;

   // R3: a strobe falls only after a clock of stable address and select
   a_r3_strobe_lags: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(any_strb_n) |-> $stable(bus_addr) && $past(!(mem_cs_n & io_cs_n)));
   a_r3_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
      (!any_strb_n && $past(!any_strb_n)) |-> $stable(bus_addr));
   // R4: memory strobes pair with the memory select, I/O with the I/O select
   a_r4_mem_pair: assert property (@(posedge clk) disable iff (!rst_n)
      (!oe_n || !we_n) |-> (!mem_cs_n && io_cs_n));
   a_r4_io_pair: assert property (@(posedge clk) disable iff (!rst_n)
      (!iord_n || !iowr_n) |-> (!io_cs_n && mem_cs_n));
   a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({oe_n, we_n, iord_n, iowr_n}) >= 3);
   // R5: I/O addresses keep the upper bits at zero
   a_r5_io_upper: assert property (@(posedge clk) disable iff (!rst_n)
      !io_cs_n |-> (bus_addr >> IO_ADDR_W) == '0);
   // R7: writes and I/O reads last at least two strobe clocks
   a_r7_we_min: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(we_n) |=> !we_n);
   a_r7_iord_min: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(iord_n) |=> !iord_n);
   // R8: the data bus is driven only under a write strobe
   a_r8_drive_write: assert property (@(posedge clk) disable iff (!rst_n)
      bus_dout_en |-> (!we_n || !iowr_n));
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
   import xbus_pkg::*;
#(
   parameter int ADDR_W     = 20,
   parameter int IO_ADDR_W  = 16,
   parameter int DATA_W     = 8,
   parameter int WAIT_W     = 3,
   parameter int MEM_RD_MIN = 0,
   parameter int OTHER_MIN  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_io,
   input  logic              req_wr,
   input  logic              req_spec,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [WAIT_W-1:0] req_waits,
   input  logic [DATA_W-1:0] bus_din,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              mem_cs_n,
   output logic              io_cs_n,
   output logic              oe_n,
   output logic              we_n,
   output logic              iord_n,
   output logic              iowr_n,
   output logic              buf_en_n,
   output logic [DATA_W-1:0] bus_dout,
   output logic              bus_dout_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              done
);
   generate
      if (IO_ADDR_W < 1 || IO_ADDR_W > ADDR_W) begin : g_bad_io_w
         $error("IO_ADDR_W must lie in 1..ADDR_W");
      end
      if (MEM_RD_MIN < 0 || MEM_RD_MIN > 1 || OTHER_MIN < 0 || OTHER_MIN > 1) begin : g_bad_min
         $error("minimum wait counts must be 0 or 1");
      end
      if (WAIT_W < 1 || DATA_W < 1) begin : g_bad_w
         $error("WAIT_W and DATA_W must be positive");
      end
   endgenerate

   phase_e            nxt_phase;
   kind_t             nxt_kind;
   logic [ADDR_W-1:0] nxt_addr;
   logic [DATA_W-1:0] nxt_wdata;

   xbus_ctrl #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_W(WAIT_W),
      .MEM_RD_MIN(MEM_RD_MIN), .OTHER_MIN(OTHER_MIN)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_io(req_io), .req_wr(req_wr),
      .req_spec(req_spec), .req_addr(req_addr), .req_wdata(req_wdata),
      .req_waits(req_waits), .bus_din(bus_din),
      .nxt_phase(nxt_phase), .nxt_kind(nxt_kind),
      .nxt_addr(nxt_addr), .nxt_wdata(nxt_wdata),
      .done(done), .rd_data(rd_data)
   );

   xbus_drive #(
      .ADDR_W(ADDR_W), .IO_ADDR_W(IO_ADDR_W), .DATA_W(DATA_W)
   ) u_drive (
      .clk(clk), .rst_n(rst_n),
      .nxt_phase(nxt_phase), .nxt_kind(nxt_kind),
      .nxt_addr(nxt_addr), .nxt_wdata(nxt_wdata),
      .bus_addr(bus_addr), .mem_cs_n(mem_cs_n), .io_cs_n(io_cs_n),
      .oe_n(oe_n), .we_n(we_n), .iord_n(iord_n), .iowr_n(iowr_n),
      .buf_en_n(buf_en_n), .bus_dout(bus_dout), .bus_dout_en(bus_dout_en)
   );

   // R10: in the completion clock the bus is fully released
   a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (mem_cs_n && io_cs_n && oe_n && we_n && iord_n && iowr_n && buf_en_n));
endmodule

// File: tb/xbus_seq_tb.sv
module xbus_seq_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_io = 1'b0, req_wr = 1'b0, req_spec = 1'b0;
   logic [19:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic [2:0]  req_waits = '0;
   logic [7:0]  bus_din = '0;
   logic [19:0] bus_addr;
   logic        mem_cs_n, io_cs_n, oe_n, we_n, iord_n, iowr_n, buf_en_n;
   logic [7:0]  bus_dout, rd_data;
   logic        bus_dout_en, done;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   xbus_seq u_dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_io(req_io), .req_wr(req_wr), .req_spec(req_spec),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_waits(req_waits),
      .bus_din(bus_din), .bus_addr(bus_addr), .mem_cs_n(mem_cs_n), .io_cs_n(io_cs_n),
      .oe_n(oe_n), .we_n(we_n), .iord_n(iord_n), .iowr_n(iowr_n), .buf_en_n(buf_en_n),
      .bus_dout(bus_dout), .bus_dout_en(bus_dout_en), .rd_data(rd_data), .done(done)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   // strobe pattern {oe_n,we_n,iord_n,iowr_n} expected while active
   function automatic logic [3:0] strobe_pat(input bit io, input bit wr);
      case ({io, wr})
         2'b00: strobe_pat = 4'b0111;
         2'b01: strobe_pat = 4'b1011;
         2'b10: strobe_pat = 4'b1101;
         default: strobe_pat = 4'b1110;
      endcase
   endfunction

   function automatic logic [19:0] exp_addr(input bit io, input logic [19:0] a);
      exp_addr = io ? {4'h0, a[15:0]} : a;
   endfunction

   task automatic drive_req(input bit io, input bit wr, input bit spec,
                            input logic [19:0] a, input logic [7:0] wd, input logic [2:0] w);
      req_valid = 1'b1; req_io = io; req_wr = wr; req_spec = spec;
      req_addr = a; req_wdata = wd; req_waits = w;
   endtask

   // After the address clock has been checked: count strobe clocks and check completion
   task automatic finish_txn(input bit io, input bit wr, input logic [19:0] a,
                             input logic [7:0] wd, input logic [7:0] din, input int exp_n,
                             input bit poke);
      int n = 0;
      logic [3:0] pat = strobe_pat(io, wr);
      bus_din = din;
      for (int k = 0; k < 20; k++) begin
         tick();
         if (poke && n == 1) req_valid = 1'b0;
         if ({oe_n, we_n, iord_n, iowr_n} == 4'b1111) break;
         n++;
         if (poke && n == 1) drive_req(1'b0, 1'b0, 1'b0, 20'h12345, 8'h00, 3'd0);
         check({oe_n, we_n, iord_n, iowr_n} == pat, "R4", "strobe pattern",
               {oe_n, we_n, iord_n, iowr_n}, pat);
         check({mem_cs_n, io_cs_n} == (io ? 2'b10 : 2'b01), "R4", "select",
               {mem_cs_n, io_cs_n}, io ? 2'b10 : 2'b01);
         check(bus_addr == exp_addr(io, a), "R3", "address held", bus_addr, exp_addr(io, a));
         check(buf_en_n == 1'b0, "R9", "buffer enable in strobe", buf_en_n, 0);
         check(bus_dout_en == wr, "R8", "drive enable", bus_dout_en, wr);
         if (wr) check(bus_dout == wd, "R8", "write byte", bus_dout, wd);
         check(done == 1'b0, "R10", "no done during strobe", done, 0);
      end
      req_valid = 1'b0;
      check(n == exp_n, (!io && !wr) ? "R6" : "R7", "strobe clocks", n, exp_n);
      check(done == 1'b1, "R10", "done after last strobe", done, 1);
      check({mem_cs_n, io_cs_n, buf_en_n, bus_dout_en} == 4'b1110, "R10", "bus released",
            {mem_cs_n, io_cs_n, buf_en_n, bus_dout_en}, 4'b1110);
      if (!wr) check(rd_data == din, "R10", "read byte", rd_data, din);
      bus_din = 8'h00;
      tick();
      check(done == 1'b0, "R10", "done single clock", done, 0);
      check({mem_cs_n, io_cs_n} == 2'b11, "R12", "no extra transfer", {mem_cs_n, io_cs_n}, 2'b11);
   endtask

   task automatic check_addr_clock(input bit io, input logic [19:0] a, input string req);
      check({oe_n, we_n, iord_n, iowr_n, buf_en_n} == 5'b11111, "R2", "no strobe in address clock",
            {oe_n, we_n, iord_n, iowr_n, buf_en_n}, 5'b11111);
      check({mem_cs_n, io_cs_n} == (io ? 2'b10 : 2'b01), req, "select in address clock",
            {mem_cs_n, io_cs_n}, io ? 2'b10 : 2'b01);
      check(bus_addr == exp_addr(io, a), req, "address in address clock", bus_addr, exp_addr(io, a));
   endtask

   task automatic run_txn(input bit io, input bit wr, input logic [19:0] a,
                          input logic [7:0] wd, input logic [2:0] w, input logic [7:0] din);
      int exp_n = int'(w) + ((!io && !wr) ? 1 : 2);
      drive_req(io, wr, 1'b0, a, wd, w);
      tick();
      req_valid = 1'b0;
      check_addr_clock(io, a, io ? "R5" : "R2");
      finish_txn(io, wr, a, wd, din, exp_n, 1'b0);
   endtask

   task automatic t_reset();
      check({mem_cs_n, io_cs_n, oe_n, we_n, iord_n, iowr_n, buf_en_n} == 7'h7F, "R1",
            "idle strobes", {mem_cs_n, io_cs_n, oe_n, we_n, iord_n, iowr_n, buf_en_n}, 7'h7F);
      check({bus_dout_en, done} == 2'b00, "R1", "idle enables", {bus_dout_en, done}, 0);
   endtask

   task automatic t_spec_abort(input bit io, input bit wr, input logic [19:0] a2, input logic [2:0] w);
      int exp_n = int'(w) + ((!io && !wr) ? 1 : 2);
      drive_req(1'b0, 1'b0, 1'b1, 20'hF0F0F, 8'h00, 3'd2);
      tick();
      check_addr_clock(1'b0, 20'hF0F0F, "R11");
      drive_req(io, wr, 1'b0, a2, 8'hC3, w);
      tick();
      req_valid = 1'b0;
      check_addr_clock(io, a2, "R11");
      finish_txn(io, wr, a2, 8'hC3, 8'h3C, exp_n, 1'b0);
   endtask

   task automatic t_ignore_busy();
      drive_req(1'b0, 1'b1, 1'b0, 20'h2468A, 8'h77, 3'd3);
      tick();
      req_valid = 1'b0;
      check_addr_clock(1'b0, 20'h2468A, "R12");
      finish_txn(1'b0, 1'b1, 20'h2468A, 8'h77, 8'h00, 5, 1'b1);
   endtask

   task automatic t_spec_complete();
      drive_req(1'b0, 1'b0, 1'b1, 20'h00400, 8'h00, 3'd0);
      tick();
      req_valid = 1'b0;
      check_addr_clock(1'b0, 20'h00400, "R11");
      finish_txn(1'b0, 1'b0, 20'h00400, 8'h00, 8'h5A, 1, 1'b0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (2) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      tick();
      t_reset();
      run_txn(1'b0, 1'b0, 20'h8ABCD, 8'h00, 3'd0, 8'hA5);  // R6 zero-wait memory read
      run_txn(1'b0, 1'b0, 20'h13579, 8'h00, 3'd7, 8'h96);  // R6 max waits
      run_txn(1'b0, 1'b1, 20'h01234, 8'h5E, 3'd0, 8'h00);  // R7 memory write forced wait
      run_txn(1'b1, 1'b0, 20'hABCDE, 8'h00, 3'd0, 8'h42);  // R5 R7 I/O read
      run_txn(1'b1, 1'b1, 20'hF1234, 8'hE1, 3'd2, 8'h00);  // R5 R7 I/O write
      t_spec_abort(1'b0, 1'b1, 20'h55555, 3'd1);          // R11 into memory write
      t_spec_abort(1'b1, 1'b0, 20'h9FEDC, 3'd0);          // R11 into I/O read
      t_spec_complete();                                   // R11 fetch not aborted
      t_ignore_busy();                                     // R12
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule